// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block is the control state machine for one rename pipeline stage. Each cycle it can take a group of up to `W` decoded instructions from decode and pass the renamed ones downstream. Each instruction carries a squashed flag, a count of destination registers and an identifier. The number renamed per cycle is limited by credits for free reorder-buffer and issue-queue entries. Each credit is reduced by the entries that may already be in flight on the feedback path. Renaming is also limited by the count of free physical registers.

When the stage cannot finish a group, it keeps the group in a skid buffer, together with a progress index that records how far into the group it got. It then raises a stall toward decode. When the blocking conditions clear, the stage replays the held groups through an unblocking state. A squash from a later stage discards everything held and parks the stage until the squash inputs drop. Map tables, the reorder buffer and the issue queue are outside this block. The block sees only their counts.

Top module: `rename_flow_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `stall_to_dec` is 0 and `out_cnt` is 0. The state codes are: 0 idle, 1 running, 2 blocked, 3 unblocking, 4 squashing.
- R2: The usable credit for each resource is its reported free count minus `W*FB_DELAY`. In one cycle the stage renames at most the minimum of the two credits.
- R3: If the smaller credit is 0 or negative, nothing is renamed. The group is held and the state becomes blocked.
- R4: If the smaller credit is positive but below the instructions still to do, exactly that many slots are consumed, the group is held and the state becomes blocked.
- R5: A slot whose squashed flag is set is not sent downstream, but it uses up one slot of the cycle's allowance. Emitted identifiers are packed from output slot 0 in group order, with `out_vld` covering the first `out_cnt` slots.
- R6: If the free physical register count, less what earlier instructions in the cycle took, is below the next instruction's destination count, renaming stops there and the state becomes blocked.
- R7: A downstream stall in a working state renames nothing, holds any incoming group and enters blocked. `stall_to_dec` is 1 in the cycle after any entry into blocked. The skid buffer never receives a push while full.
- R8: The blocked state emits nothing and keeps `stall_to_dec` at 1. It moves on only once the downstream stall is low, both credits are positive and free registers are nonzero.
- R9: In the unblocking state, the head held group resumes at its stored progress index and is removed once finished. `stall_to_dec` stays 1 until no group is held, and then the state returns to running.
- R10: Any cycle with `squash` or `rob_squashing` high discards all held groups and enters squashing with `stall_to_dec` low. Squashing lasts until both inputs are low. Discarded groups never reappear.
- R11: A group that completes without blocking resets the progress index to 0, so the next group starts at its slot 0.
- R12: The idle state moves to running when the first nonempty group completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_cnt | input | CW | Number of instructions in the incoming group (0 = none) |
| in_squashed | input | W | Per-slot squashed flag |
| in_ndst | input | W*DW | Per-slot destination register count |
| in_id | input | W*IW | Per-slot instruction identifier |
| ds_stall | input | 1 | Stall from later stages |
| squash | input | 1 | Squash request |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| free_rob | input | CRW | Reported free reorder-buffer entries |
| free_iq | input | CRW | Reported free issue-queue entries |
| free_pregs | input | PRW | Free physical registers |
| stall_to_dec | output | 1 | Stall toward decode (registered) |
| out_vld | output | W | Valid mask of downstream slots |
| out_cnt | output | CW | Number of instructions sent downstream |
| out_id | output | W*IW | Packed identifiers of emitted instructions |
| state_o | output | 3 | Current control state |

## Verification
The bench uses the default configuration: four slots, a feedback delay of one cycle (a credit offset of 4) and a four-group skid buffer. With these values, a credit sweep over free counts 2 to 11 on both resources covers negative, zero, partial and full allowances. Each combination gets an arithmetic expectation for count, state and first identifier. Directed sequences with small register counts and mixed squashed masks cover a stop partway through a group and the resume index. They also cover the blocked-to-unblocking gates one at a time, and a squash that discards held work.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RUN     = 3'd1,
      ST_BLOCKED = 3'd2,
      ST_UNBLOCK = 3'd3,
      ST_SQUASH  = 3'd4
   } rfc_state_e;
endpackage

// File: rtl/rfc_credit.sv
module rfc_credit #(
   parameter int W   = 4,
   parameter int FB  = 1,
   parameter int CRW = 6,
   localparam int SW = CRW + 2
) (
   input  logic [CRW-1:0]       free_cnt,
   output logic signed [SW-1:0] credit,
   output logic                 positive
);
   localparam int RESV = W * FB;

   always_comb begin
      credit   = $signed({2'b00, free_cnt}) - SW'(RESV);
      positive = credit > 0;
   end
endmodule

// File: rtl/rfc_skid.sv
module rfc_skid #(
   parameter int DEPTH = 4,
   parameter int GW    = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int NW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush,
   input  logic          push,
   input  logic [GW-1:0] push_grp,
   input  logic          pop,
   output logic [GW-1:0] head,
   output logic          empty,
   output logic          full,
   output logic [NW-1:0] count
);
   logic [GW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
   endfunction

   assign empty = (count == '0);
   assign full  = (int'(count) == DEPTH);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         count <= count + NW'(push) - NW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= push_grp;
   end

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
      (push && !flush) |-> !full);
   a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
      (pop && !flush) |-> !empty);
endmodule

// File: rtl/rfc_slot_walk.sv
module rfc_slot_walk #(
   parameter int W   = 4,
   parameter int DW  = 2,
   parameter int IW  = 8,
   parameter int SW  = 8,
   parameter int PRW = 6,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [CW-1:0]        grp_cnt,
   input  logic [W-1:0]         grp_sq,
   input  logic [W*DW-1:0]      grp_ndst,
   input  logic [W*IW-1:0]      grp_id,
   input  logic [CW-1:0]        start,
   input  logic signed [SW-1:0] limit,
   input  logic [PRW-1:0]       pregs,
   output logic [W*IW-1:0]      emit_id,
   output logic [CW-1:0]        emit_n,
   output logic [CW-1:0]        next_idx,
   output logic                 must_block
);
   always_comb begin : walk
      int avail, rem, pr, n, idx;
      logic stop, cap_hit;
      avail   = (grp_cnt > start) ? int'(grp_cnt) - int'(start) : 0;
      cap_hit = int'(limit) < avail;
      rem     = cap_hit ? int'(limit) : avail;
      pr      = int'(pregs);
      n       = 0;
      idx     = int'(start);
      stop    = 1'b0;
      emit_id = '0;
      for (int j = 0; j < W; j++) begin
         if (j >= int'(start) && j < int'(grp_cnt) && rem > 0 && !stop) begin
            if (grp_sq[j]) begin
               idx = j + 1;
               rem = rem - 1;
            end else if (pr < int'(grp_ndst[j*DW +: DW])) begin
               stop = 1'b1;
            end else begin
               emit_id[n*IW +: IW] = grp_id[j*IW +: IW];
               n   = n + 1;
               pr  = pr - int'(grp_ndst[j*DW +: DW]);
               idx = j + 1;
               rem = rem - 1;
            end
         end
      end
      emit_n     = CW'(n);
      next_idx   = CW'(idx);
      must_block = cap_hit || stop;
   end
endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl
   import rfc_pkg::*;
#(
   parameter int W        = 4,
   parameter int DW       = 2,
   parameter int IW       = 8,
   parameter int CRW      = 6,
   parameter int PRW      = 6,
   parameter int FB_DELAY = 1,
   parameter int DEPTH    = 4,
   localparam int CW      = $clog2(W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CW-1:0]     in_cnt,
   input  logic [W-1:0]      in_squashed,
   input  logic [W*DW-1:0]   in_ndst,
   input  logic [W*IW-1:0]   in_id,
   input  logic              ds_stall,
   input  logic              squash,
   input  logic              rob_squashing,
   input  logic [CRW-1:0]    free_rob,
   input  logic [CRW-1:0]    free_iq,
   input  logic [PRW-1:0]    free_pregs,
   output logic              stall_to_dec,
   output logic [W-1:0]      out_vld,
   output logic [CW-1:0]     out_cnt,
   output logic [W*IW-1:0]   out_id,
   output logic [2:0]        state_o
);
   localparam int SW  = CRW + 2;
   localparam int GW  = CW + W + W*DW + W*IW;
   localparam int NW  = $clog2(DEPTH + 1);
   localparam int O_SQ = CW;
   localparam int O_ND = CW + W;
   localparam int O_ID = CW + W + W*DW;

   if (W < 1 || DEPTH < 2 || FB_DELAY < 0 || DW < 1 || IW < 1) begin : g_bad_shape
      $error("rename_flow_ctrl: illegal shape parameters");
   end
   if (W * FB_DELAY >= (1 << CRW)) begin : g_bad_credit
      $error("rename_flow_ctrl: credit reservation does not fit CRW");
   end

   rfc_state_e      state_q, state_d;
   logic [CW-1:0]   idx_q, idx_d;
   logic            stall_q, stall_d;
   logic [CW-1:0]   out_cnt_q;
   logic [W*IW-1:0] out_id_q;

   logic signed [SW-1:0] rob_cr, iq_cr, min_cr;
   logic                 rob_ok, iq_ok;

   rfc_credit #(.W(W), .FB(FB_DELAY), .CRW(CRW)) u_rob_cr (
      .free_cnt(free_rob), .credit(rob_cr), .positive(rob_ok));
   rfc_credit #(.W(W), .FB(FB_DELAY), .CRW(CRW)) u_iq_cr (
      .free_cnt(free_iq), .credit(iq_cr), .positive(iq_ok));

   assign min_cr = (rob_cr < iq_cr) ? rob_cr : iq_cr;

   logic [GW-1:0] in_grp, skid_head, src_grp;
   logic          skid_push, skid_pop, skid_flush, skid_empty, skid_full;
   logic [NW-1:0] skid_count;

   assign in_grp = {in_id, in_ndst, in_squashed, in_cnt};

   rfc_skid #(.DEPTH(DEPTH), .GW(GW)) u_skid (
      .clk(clk), .rst(rst), .flush(skid_flush),
      .push(skid_push), .push_grp(in_grp), .pop(skid_pop),
      .head(skid_head), .empty(skid_empty), .full(skid_full),
      .count(skid_count));

   assign src_grp = (state_q == ST_UNBLOCK) ? skid_head : in_grp;

   logic [W*IW-1:0] w_id;
   logic [CW-1:0]   w_n, w_idx;
   logic            w_block;

   rfc_slot_walk #(.W(W), .DW(DW), .IW(IW), .SW(SW), .PRW(PRW)) u_walk (
      .grp_cnt(src_grp[CW-1:0]),
      .grp_sq(src_grp[O_SQ +: W]),
      .grp_ndst(src_grp[O_ND +: W*DW]),
      .grp_id(src_grp[O_ID +: W*IW]),
      .start(idx_q),
      .limit(min_cr),
      .pregs(free_pregs),
      .emit_id(w_id),
      .emit_n(w_n),
      .next_idx(w_idx),
      .must_block(w_block));

   logic has_in, emit, any_squash, work;

   always_comb begin
      has_in     = (in_cnt != '0);
      any_squash = squash || rob_squashing;
      work       = (state_q == ST_UNBLOCK) || has_in;
      state_d    = state_q;
      idx_d      = idx_q;
      stall_d    = 1'b0;
      skid_push  = 1'b0;
      skid_pop   = 1'b0;
      skid_flush = 1'b0;
      emit       = 1'b0;
      if (any_squash) begin
         skid_flush = 1'b1;
         idx_d      = '0;
         state_d    = ST_SQUASH;
      end else if (state_q == ST_BLOCKED) begin
         stall_d   = 1'b1;
         skid_push = has_in;
         if (!ds_stall && rob_ok && iq_ok && free_pregs != '0)
            state_d = (skid_empty && !has_in) ? ST_RUN : ST_UNBLOCK;
      end else if (ds_stall) begin
         state_d   = ST_BLOCKED;
         stall_d   = 1'b1;
         skid_push = has_in;
      end else if (!work) begin
         if (state_q == ST_SQUASH) state_d = ST_RUN;
      end else if (min_cr <= 0) begin
         state_d   = ST_BLOCKED;
         stall_d   = 1'b1;
         skid_push = has_in;
      end else begin
         emit = 1'b1;
         if (w_block) begin
            state_d   = ST_BLOCKED;
            stall_d   = 1'b1;
            skid_push = has_in;
            idx_d     = w_idx;
         end else begin
            idx_d = '0;
            if (state_q == ST_UNBLOCK) begin
               skid_pop  = 1'b1;
               skid_push = has_in;
               if (int'(skid_count) - 1 + int'(has_in) == 0) begin
                  state_d = ST_RUN;
               end else begin
                  state_d = ST_UNBLOCK;
                  stall_d = 1'b1;
               end
            end else begin
               state_d = ST_RUN;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         stall_q   <= 1'b0;
         out_cnt_q <= '0;
         out_id_q  <= '0;
      end else begin
         state_q   <= state_d;
         idx_q     <= idx_d;
         stall_q   <= stall_d;
         out_cnt_q <= emit ? w_n : '0;
         out_id_q  <= emit ? w_id : '0;
      end
   end

   for (genvar k = 0; k < W; k++) begin : g_vld
      assign out_vld[k] = (int'(out_cnt_q) > k);
   end

   assign stall_to_dec = stall_q;
   assign out_cnt      = out_cnt_q;
   assign out_id       = out_id_q;
   assign state_o      = state_q;

   a_r10_squash_enter: assert property (@(posedge clk) disable iff (rst)
      (squash || rob_squashing) |=> (state_q == ST_SQUASH && !stall_q));
   a_r8_blocked_silent: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_BLOCKED && !squash && !rob_squashing) |=> (out_cnt_q == '0));
   a_r7_blocked_stalls: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_BLOCKED) |-> stall_q);
   a_r9_unblock_has_work: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_UNBLOCK) |-> !skid_empty);
   a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
      int'(out_cnt_q) <= W);
endmodule

// File: tb/rename_flow_ctrl_tb.sv
module rename_flow_ctrl_tb;
   localparam int W = 4, DW = 2, IW = 8, CRW = 6, PRW = 6, FB = 1, DEPTH = 4;
   localparam int CW = $clog2(W + 1);
   localparam int RESV = W * FB;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [CW-1:0]   in_cnt = '0;
   logic [W-1:0]    in_squashed = '0;
   logic [W*DW-1:0] in_ndst = '0;
   logic [W*IW-1:0] in_id = '0;
   logic ds_stall = 1'b0, squash = 1'b0, rob_squashing = 1'b0;
   logic [CRW-1:0] free_rob = 6'd20, free_iq = 6'd20;
   logic [PRW-1:0] free_pregs = 6'd30;
   logic stall_to_dec;
   logic [W-1:0] out_vld;
   logic [CW-1:0] out_cnt;
   logic [W*IW-1:0] out_id;
   logic [2:0] state_o;

   int checks = 0, failures = 0;

   always #2 clk = ~clk;

   rename_flow_ctrl #(.W(W), .DW(DW), .IW(IW), .CRW(CRW), .PRW(PRW),
                      .FB_DELAY(FB), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_squashed(in_squashed),
      .in_ndst(in_ndst), .in_id(in_id), .ds_stall(ds_stall), .squash(squash),
      .rob_squashing(rob_squashing), .free_rob(free_rob), .free_iq(free_iq),
      .free_pregs(free_pregs), .stall_to_dec(stall_to_dec), .out_vld(out_vld),
      .out_cnt(out_cnt), .out_id(out_id), .state_o(state_o));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic grp(input int cnt, input logic [W-1:0] sq, input int base);
      in_cnt      = CW'(cnt);
      in_squashed = sq;
      for (int j = 0; j < W; j++) begin
         in_ndst[j*DW +: DW] = DW'(1);
         in_id[j*IW +: IW]   = IW'(base + j);
      end
   endtask

   task automatic nogrp();
      in_cnt = '0;
      in_squashed = '0;
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int oid(input int k);
      return int'(out_id[k*IW +: IW]);
   endfunction

   task automatic expect_out(input string req, input int st, input int stl, input int n, input int id0);
      chk(req, "state", int'(state_o), st);
      chk(req, "stall", int'(stall_to_dec), stl);
      chk(req, "count", int'(out_cnt), n);
      chk(req, "valid", int'(out_vld), (1 << n) - 1);
      if (n > 0) chk(req, "id0", oid(0), id0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      expect_out("R1", 0, 0, 0, 0);

      // R12 idle to running on first group
      grp(4, 4'b0000, 'h10);
      cyc();
      expect_out("R12", 1, 0, 4, 'h10);
      chk("R12", "id3", oid(3), 'h13);

      // R5 squashed slots 0 and 2 skipped, output packed
      grp(4, 4'b0101, 'h20);
      cyc();
      expect_out("R5", 1, 0, 2, 'h21);
      chk("R5", "id1", oid(1), 'h23);

      // R6 register shortage stops after two
      free_pregs = 6'd2;
      grp(4, 4'b0000, 'h30);
      cyc();
      expect_out("R6", 2, 1, 2, 'h30);
      chk("R6", "id1", oid(1), 'h31);
      nogrp();
      free_pregs = 6'd30;
      cyc();
      expect_out("R8", 3, 1, 0, 0);
      cyc();
      expect_out("R9", 1, 0, 2, 'h32);
      chk("R9", "id1", oid(1), 'h33);
      // R11 next group starts at slot 0
      grp(4, 4'b0000, 'h40);
      cyc();
      expect_out("R11", 1, 0, 4, 'h40);

      // R7 downstream stall holds group
      ds_stall = 1'b1;
      grp(4, 4'b0000, 'h50);
      cyc();
      expect_out("R7", 2, 1, 0, 0);
      nogrp();
      cyc();
      expect_out("R8", 2, 1, 0, 0);
      ds_stall = 1'b0;
      free_pregs = 6'd0;
      cyc();
      expect_out("R8", 2, 1, 0, 0);
      free_pregs = 6'd30;
      cyc();
      expect_out("R8", 3, 1, 0, 0);
      cyc();
      expect_out("R9", 1, 0, 4, 'h50);

      // R4 partial credit, then resume at index 2
      free_rob = 6'(RESV + 2);
      grp(4, 4'b0000, 'h60);
      cyc();
      expect_out("R4", 2, 1, 2, 'h60);
      nogrp();
      free_rob = 6'd20;
      cyc();
      expect_out("R4", 3, 1, 0, 0);
      cyc();
      expect_out("R4", 1, 0, 2, 'h62);

      // R3 zero issue-queue credit
      free_iq = 6'(RESV);
      grp(4, 4'b0000, 'h70);
      cyc();
      expect_out("R3", 2, 1, 0, 0);
      nogrp();
      cyc();
      expect_out("R8", 2, 1, 0, 0);
      free_iq = 6'd20;
      cyc();
      expect_out("R8", 3, 1, 0, 0);
      cyc();
      expect_out("R3", 1, 0, 4, 'h70);

      // R10 squash discards held group
      free_rob = 6'(RESV);
      grp(4, 4'b0000, 'h80);
      cyc();
      expect_out("R10", 2, 1, 0, 0);
      nogrp();
      free_rob = 6'd20;
      squash = 1'b1;
      cyc();
      expect_out("R10", 4, 0, 0, 0);
      squash = 1'b0;
      rob_squashing = 1'b1;
      cyc();
      expect_out("R10", 4, 0, 0, 0);
      rob_squashing = 1'b0;
      cyc();
      expect_out("R10", 1, 0, 0, 0);
      cyc();
      expect_out("R10", 1, 0, 0, 0);

      // R2 credit sweep over both resources
      for (int r = 2; r < 12; r++) begin
         for (int q = 2; q < 12; q++) begin
            int m, n, st;
            nogrp();
            squash = 1'b1;
            cyc();
            squash = 1'b0;
            cyc();
            free_rob = 6'(r);
            free_iq  = 6'(q);
            grp(4, 4'b0000, 'hA0);
            cyc();
            m  = ((r < q) ? r : q) - RESV;
            n  = (m <= 0) ? 0 : ((m < 4) ? m : 4);
            st = (m >= 4) ? 1 : 2;
            expect_out("R2", st, (st == 2) ? 1 : 0, n, 'hA0);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule